// File: doc/BRIEF.md
# Message Interrupt Remapping Unit

This unit sits between devices that raise interrupts by writing a message and the local interrupt controller of a processor. An incoming interrupt write names only its source (a 16-bit requester ID) and a small message index; it carries no vector and no target. The unit uses the requester ID to pick that device's own remapping table in memory, uses the index to pick an entry in it, and sends out an interrupt message that carries the entry's 8-bit vector and 8-bit destination processor ID.

A small fully associative cache of recently used entries, keyed by requester ID and index, lets repeat interrupts go out without a memory read. Software removes stale cached entries through an invalidation port, by key or all at once. On a miss the unit stops taking new interrupts until the table read returns, so deliveries leave in the order the interrupts were accepted. An index past the end of the table, or a table entry marked not valid, drops the interrupt and raises a one-cycle error pulse that carries the offending requester ID.

Top module: `msg_irq_remap`

## Requirements
- R1: After reset, msgReady is high and irqValid, errPulse and memReqValid are low.
- R2: An accepted interrupt that misses the cache raises memReqValid for exactly one cycle, the cycle after acceptance, with memReqAddr = requester ID * TBL_ENTRIES + index (requester ID in the high bits, index in the low log2(TBL_ENTRIES) bits, in units of 64-bit entries); msgReady stays low from that cycle until the cycle after the response, so no later interrupt is accepted or delivered before it.
- R3: A table entry is 64 bits: bit 0 is the valid flag, bits 15:8 the vector, bits 31:24 the destination ID, all other bits are ignored; a response with bit 0 set gives irqValid for one cycle, the cycle after memRspValid, with those fields.
- R4: A response with bit 0 clear delivers nothing and gives errPulse for one cycle, the cycle after memRspValid, with errReqId equal to the requester ID of that interrupt.
- R5: An accepted interrupt whose index is TBL_ENTRIES or more gives errPulse the next cycle with its requester ID, issues no read, delivers nothing and keeps msgReady high.
- R6: An accepted interrupt whose key is cached gives irqValid the next cycle with the cached vector and destination, issues no read and keeps msgReady high.
- R7: Only entries read with bit 0 set are cached, keyed by requester ID and index; a not-valid entry is read again each time it is used.
- R8: The cache has CACHE_WAYS slots (8 by default) filled in round-robin order, so the (CACHE_WAYS+1)-th fill evicts the oldest fill.
- R9: An invalidation removes the cached entry with the given key, or every entry when invAll is set; it takes effect for an interrupt accepted in the same cycle, which then misses.
- R10: An invalidation that matches the key of a read still in flight lets that interrupt be delivered but keeps its entry out of the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Interrupt write present |
| msgReady | output | 1 | Unit can accept an interrupt write |
| msgReqId | input | REQ_W | Requester ID of the interrupting device |
| msgIndex | input | IDX_W | Message index into that device's table |
| invValid | input | 1 | Cache invalidation request |
| invAll | input | 1 | Invalidate every cached entry |
| invReqId | input | REQ_W | Requester ID of the entry to invalidate |
| invIndex | input | log2(TBL_ENTRIES) | Index of the entry to invalidate |
| memReqValid | output | 1 | Table read request, one cycle |
| memReqAddr | output | REQ_W+log2(TBL_ENTRIES) | Entry address of the read |
| memRspValid | input | 1 | Table read data present |
| memRspData | input | 64 | Table entry read |
| irqValid | output | 1 | Remapped interrupt message, one cycle |
| irqVector | output | 8 | Interrupt vector |
| irqDest | output | 8 | Destination processor ID |
| errPulse | output | 1 | Dropped interrupt, one cycle |
| errReqId | output | REQ_W | Requester ID of the dropped interrupt |

## Verification
On every cycle the assertions check that a table read only follows an acceptance, lasts one cycle and holds the input stalled, that a delivery only follows an acceptance or a read response, that a delivery and an error never coincide, and that an out-of-range index is dropped with the right requester ID. Whether a given interrupt hits or misses depends on the cache contents, so round-robin eviction, invalidation by key and in bulk, invalidation racing an acceptance or a read in flight, and the stale vector returned by a cached entry after the table changes can only be shown by the bench scenarios against its reference model.

// File: rtl/msg_irq_remap_pkg.sv
package msg_irq_remap_pkg;

  // Bit positions inside a 64-bit remapping table entry
  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_VEC_LSB   = 8;
  localparam int ENT_DST_LSB   = 24;
  localparam int ENT_W         = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } remapState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic acceptHit;   // deliver from cache
    logic rangeErr;    // drop incoming, index out of range
    logic latchKey;    // capture incoming key for a miss
    logic deliverFill; // deliver from read response
    logic entryErr;    // drop pending, entry not valid
  } ctrlStrobe_t;

endpackage

// File: rtl/msg_irq_remap_cache.sv
module msg_irq_remap_cache #(
  parameter int REQ_W = 16,
  parameter int KEY_W = 5,
  parameter int WAYS  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REQ_W-1:0] lookReq,
  input  logic [KEY_W-1:0] lookIdx,
  output logic             lookHit,
  output logic [7:0]       lookVec,
  output logic [7:0]       lookDst,
  input  logic             invValid,
  input  logic             invAll,
  input  logic [REQ_W-1:0] invReq,
  input  logic [KEY_W-1:0] invIdx,
  input  logic             fillEn,
  input  logic [REQ_W-1:0] fillReq,
  input  logic [KEY_W-1:0] fillIdx,
  input  logic [7:0]       fillVec,
  input  logic [7:0]       fillDst
);

  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  wayValid;
  logic [REQ_W-1:0] wayReq [WAYS];
  logic [KEY_W-1:0] wayIdx [WAYS];
  logic [7:0]       wayVec [WAYS];
  logic [7:0]       wayDst [WAYS];
  logic [WAYS-1:0]  wayHit;
  logic [WAYS-1:0]  wayKill;
  logic [PTR_W-1:0] victim;

  for (genvar g = 0; g < WAYS; g++) begin : gWay
    assign wayKill[g] = invValid && (invAll || (wayReq[g] == invReq && wayIdx[g] == invIdx));
    // an entry being invalidated this cycle no longer counts as a hit
    assign wayHit[g]  = wayValid[g] && (wayReq[g] == lookReq) && (wayIdx[g] == lookIdx) && !wayKill[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wayValid[g] <= 1'b0;
        wayReq[g]   <= '0;
        wayIdx[g]   <= '0;
        wayVec[g]   <= '0;
        wayDst[g]   <= '0;
      end else if (fillEn && victim == PTR_W'(g)) begin
        wayValid[g] <= 1'b1;
        wayReq[g]   <= fillReq;
        wayIdx[g]   <= fillIdx;
        wayVec[g]   <= fillVec;
        wayDst[g]   <= fillDst;
      end else if (wayKill[g]) begin
        wayValid[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victim <= '0;
    end else if (fillEn) begin
      victim <= (victim == PTR_W'(WAYS - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_comb begin
    lookHit = |wayHit;
    lookVec = '0;
    lookDst = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (wayHit[i]) begin
        lookVec = lookVec | wayVec[i];
        lookDst = lookDst | wayDst[i];
      end
    end
  end

endmodule

// File: rtl/msg_irq_remap_ctrl.sv
module msg_irq_remap_ctrl
  import msg_irq_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msgValid,
  input  logic        inRange,
  input  logic        hit,
  input  logic        memRspValid,
  input  logic        rspOk,
  output logic        msgReady,
  output logic        memReqValid,
  output ctrlStrobe_t strb
);

  remapState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (msgValid) begin
          if (!inRange) begin
            strb.rangeErr = 1'b1;
          end else if (hit) begin
            strb.acceptHit = 1'b1;
          end else begin
            strb.latchKey = 1'b1;
            nextState     = ST_FETCH;
          end
        end
      end
      ST_FETCH: nextState = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (rspOk) strb.deliverFill = 1'b1;
          else       strb.entryErr    = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign msgReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_FETCH);

endmodule

// File: rtl/msg_irq_remap_dp.sv
module msg_irq_remap_dp
  import msg_irq_remap_pkg::*;
#(
  parameter int REQ_W       = 16,
  parameter int IDX_W       = 8,
  parameter int TBL_ENTRIES = 32,
  parameter int CACHE_WAYS  = 8,
  parameter int TBL_AW      = $clog2(TBL_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  input  logic [REQ_W-1:0]        msgReqId,
  input  logic [IDX_W-1:0]        msgIndex,
  input  logic                    invValid,
  input  logic                    invAll,
  input  logic [REQ_W-1:0]        invReqId,
  input  logic [TBL_AW-1:0]       invIndex,
  input  logic [ENT_W-1:0]        memRspData,
  output logic                    inRange,
  output logic                    hit,
  output logic                    rspOk,
  output logic [REQ_W+TBL_AW-1:0] memReqAddr,
  output logic                    irqValid,
  output logic [7:0]              irqVector,
  output logic [7:0]              irqDest,
  output logic                    errPulse,
  output logic [REQ_W-1:0]        errReqId
);

  logic [TBL_AW-1:0] msgIdxT;
  logic [REQ_W-1:0]  pendReq;
  logic [TBL_AW-1:0] pendIdx;
  logic              killQ;
  logic              invIncoming;
  logic              invPending;
  logic              fillEn;
  logic [7:0]        hitVec, hitDst, rspVec, rspDst;
  logic              rspUnused;

  assign msgIdxT = msgIndex[TBL_AW-1:0];
  assign inRange = (msgIndex < IDX_W'(TBL_ENTRIES));

  assign rspOk  = memRspData[ENT_VALID_BIT];
  assign rspVec = memRspData[ENT_VEC_LSB +: 8];
  assign rspDst = memRspData[ENT_DST_LSB +: 8];
  assign rspUnused = ^{memRspData[ENT_W-1:ENT_DST_LSB+8], memRspData[ENT_DST_LSB-1:ENT_VEC_LSB+8],
                       memRspData[ENT_VEC_LSB-1:ENT_VALID_BIT+1]};

  assign invIncoming = invValid && (invAll || (invReqId == msgReqId && invIndex == msgIdxT));
  assign invPending  = invValid && (invAll || (invReqId == pendReq && invIndex == pendIdx));
  assign fillEn      = strb.deliverFill && !killQ && !invPending;

  assign memReqAddr = {pendReq, pendIdx};

  msg_irq_remap_cache #(
    .REQ_W(REQ_W),
    .KEY_W(TBL_AW),
    .WAYS (CACHE_WAYS)
  ) cacheI (
    .clk     (clk),
    .rstN    (rstN),
    .lookReq (msgReqId),
    .lookIdx (msgIdxT),
    .lookHit (hit),
    .lookVec (hitVec),
    .lookDst (hitDst),
    .invValid(invValid),
    .invAll  (invAll),
    .invReq  (invReqId),
    .invIdx  (invIndex),
    .fillEn  (fillEn),
    .fillReq (pendReq),
    .fillIdx (pendIdx),
    .fillVec (rspVec),
    .fillDst (rspDst)
  );

  // pending key of the outstanding miss and its kill mark
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReq <= '0;
      pendIdx <= '0;
      killQ   <= 1'b0;
    end else if (strb.latchKey) begin
      pendReq <= msgReqId;
      pendIdx <= msgIdxT;
      killQ   <= invIncoming;
    end else if (invPending) begin
      killQ   <= 1'b1;
    end
  end

  // registered delivery and error outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
      irqDest   <= '0;
      errPulse  <= 1'b0;
      errReqId  <= '0;
    end else begin
      irqValid <= strb.acceptHit || strb.deliverFill;
      errPulse <= strb.rangeErr || strb.entryErr;
      if (strb.acceptHit) begin
        irqVector <= hitVec;
        irqDest   <= hitDst;
      end else if (strb.deliverFill) begin
        irqVector <= rspVec;
        irqDest   <= rspDst;
      end
      if (strb.rangeErr)      errReqId <= msgReqId;
      else if (strb.entryErr) errReqId <= pendReq;
    end
  end

endmodule

// File: rtl/msg_irq_remap.sv
module msg_irq_remap
  import msg_irq_remap_pkg::*;
#(
  parameter int REQ_W       = 16,
  parameter int IDX_W       = 8,
  parameter int TBL_ENTRIES = 32,
  parameter int CACHE_WAYS  = 8,
  parameter int TBL_AW      = $clog2(TBL_ENTRIES),
  parameter int ADDR_W      = REQ_W + TBL_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  output logic              msgReady,
  input  logic [REQ_W-1:0]  msgReqId,
  input  logic [IDX_W-1:0]  msgIndex,
  input  logic              invValid,
  input  logic              invAll,
  input  logic [REQ_W-1:0]  invReqId,
  input  logic [TBL_AW-1:0] invIndex,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  output logic              irqValid,
  output logic [7:0]        irqVector,
  output logic [7:0]        irqDest,
  output logic              errPulse,
  output logic [REQ_W-1:0]  errReqId
);

  ctrlStrobe_t strb;
  logic        inRange, hit, rspOk;

  msg_irq_remap_ctrl ctrlI (
    .clk        (clk),
    .rstN       (rstN),
    .msgValid   (msgValid),
    .inRange    (inRange),
    .hit        (hit),
    .memRspValid(memRspValid),
    .rspOk      (rspOk),
    .msgReady   (msgReady),
    .memReqValid(memReqValid),
    .strb       (strb)
  );

  msg_irq_remap_dp #(
    .REQ_W      (REQ_W),
    .IDX_W      (IDX_W),
    .TBL_ENTRIES(TBL_ENTRIES),
    .CACHE_WAYS (CACHE_WAYS),
    .TBL_AW     (TBL_AW)
  ) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .msgReqId  (msgReqId),
    .msgIndex  (msgIndex),
    .invValid  (invValid),
    .invAll    (invAll),
    .invReqId  (invReqId),
    .invIndex  (invIndex),
    .memRspData(memRspData),
    .inRange   (inRange),
    .hit       (hit),
    .rspOk     (rspOk),
    .memReqAddr(memReqAddr),
    .irqValid  (irqValid),
    .irqVector (irqVector),
    .irqDest   (irqDest),
    .errPulse  (errPulse),
    .errReqId  (errReqId)
  );

endmodule

// File: rtl/msg_irq_remap_chk.sv
module msg_irq_remap_chk #(
  parameter int REQ_W       = 16,
  parameter int IDX_W       = 8,
  parameter int TBL_ENTRIES = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic             msgReady,
  input logic [REQ_W-1:0] msgReqId,
  input logic [IDX_W-1:0] msgIndex,
  input logic             memReqValid,
  input logic             memRspValid,
  input logic             irqValid,
  input logic             errPulse,
  input logic [REQ_W-1:0] errReqId
);

  // R2
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(msgValid && msgReady));

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> (!memReqValid && !msgReady));

  // R2
  stall_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !msgReady);

  // R5
  range_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady && msgIndex >= IDX_W'(TBL_ENTRIES)) |=>
      (errPulse && !irqValid && !memReqValid && msgReady && errReqId == $past(msgReqId)));

  // R3
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(msgValid && msgReady) || $past(memRspValid)));

  // R4
  irq_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqValid && errPulse));

endmodule

bind msg_irq_remap msg_irq_remap_chk #(
  .REQ_W      (REQ_W),
  .IDX_W      (IDX_W),
  .TBL_ENTRIES(TBL_ENTRIES)
) chkI (
  .clk        (clk),
  .rstN       (rstN),
  .msgValid   (msgValid),
  .msgReady   (msgReady),
  .msgReqId   (msgReqId),
  .msgIndex   (msgIndex),
  .memReqValid(memReqValid),
  .memRspValid(memRspValid),
  .irqValid   (irqValid),
  .errPulse   (errPulse),
  .errReqId   (errReqId)
);

// File: tb/msg_irq_remap_test.sv
module msg_irq_remap_test;

  localparam int REQ_W = 16;
  localparam int IDX_W = 8;
  localparam int TBL   = 32;
  localparam int AW    = 5;
  localparam int WAYS  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              msgValid = 1'b0;
  logic              msgReady;
  logic [REQ_W-1:0]  msgReqId = '0;
  logic [IDX_W-1:0]  msgIndex = '0;
  logic              invValid = 1'b0;
  logic              invAll = 1'b0;
  logic [REQ_W-1:0]  invReqId = '0;
  logic [AW-1:0]     invIndex = '0;
  logic              memReqValid;
  logic [REQ_W+AW-1:0] memReqAddr;
  logic              memRspValid = 1'b0;
  logic [63:0]       memRspData = '0;
  logic              irqValid;
  logic [7:0]        irqVector, irqDest;
  logic              errPulse;
  logic [REQ_W-1:0]  errReqId;

  always #4 clk = ~clk;

  msg_irq_remap uut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
    .msgReqId(msgReqId), .msgIndex(msgIndex), .invValid(invValid), .invAll(invAll),
    .invReqId(invReqId), .invIndex(invIndex), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .irqValid(irqValid), .irqVector(irqVector), .irqDest(irqDest),
    .errPulse(errPulse), .errReqId(errReqId)
  );

  int vecCount = 0;
  int missCount = 0;
  int reads = 0, irqs = 0, errs = 0;
  int memLat = 1;
  int rspCnt = 0;
  logic [REQ_W+AW-1:0] rdAddr = '0;
  logic [7:0] epoch = 8'h00;
  bit running = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  // table contents: index%4==3 entries are not valid; reserved bits are nonzero
  function automatic logic [63:0] entryFor(input logic [REQ_W+AW-1:0] a, input logic [7:0] ep);
    logic valid;
    valid = (a[1:0] != 2'b11);
    return {32'hA5A5_A5A5, a[15:8] + ep, 8'hFF, a[7:0] ^ ep, 7'h2A, valid};
  endfunction

  // ---------------- reference model ----------------
  int mState = 0;
  bit cVal [WAYS];
  logic [REQ_W-1:0] cReq [WAYS];
  logic [AW-1:0]    cIdx [WAYS];
  logic [7:0]       cVec [WAYS];
  logic [7:0]       cDst [WAYS];
  int ptr = 0;
  logic [REQ_W-1:0] pReq = '0;
  logic [AW-1:0]    pIdx = '0;
  bit kill = 1'b0;
  bit mIrq = 1'b0, mErr = 1'b0;
  logic [7:0] mVec = '0, mDst = '0;
  logic [REQ_W-1:0] mErrId = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; ptr = 0; kill = 1'b0; mIrq = 1'b0; mErr = 1'b0;
      for (int i = 0; i < WAYS; i++) cVal[i] = 1'b0;
    end else begin
      bit invP, invIn, doFill;
      int hs;
      doFill = 1'b0;
      mIrq = 1'b0;
      mErr = 1'b0;
      invP = invValid && (invAll || (invReqId == pReq && invIndex == pIdx));
      case (mState)
        0: if (msgValid) begin
          if (msgIndex >= TBL) begin
            mErr = 1'b1; mErrId = msgReqId;
          end else begin
            invIn = invValid && (invAll || (invReqId == msgReqId && invIndex == msgIndex[AW-1:0]));
            hs = -1;
            for (int i = 0; i < WAYS; i++)
              if (cVal[i] && cReq[i] == msgReqId && cIdx[i] == msgIndex[AW-1:0] && !invIn) hs = i;
            if (hs >= 0) begin
              mIrq = 1'b1; mVec = cVec[hs]; mDst = cDst[hs];
            end else begin
              pReq = msgReqId; pIdx = msgIndex[AW-1:0]; kill = invIn; mState = 1;
            end
          end
        end
        1: begin
          if (invP) kill = 1'b1;
          mState = 2;
        end
        default: begin
          if (invP) kill = 1'b1;
          if (memRspValid) begin
            if (memRspData[0]) begin
              mIrq = 1'b1; mVec = memRspData[15:8]; mDst = memRspData[31:24];
              doFill = !kill;
            end else begin
              mErr = 1'b1; mErrId = pReq;
            end
            mState = 0;
          end
        end
      endcase
      for (int i = 0; i < WAYS; i++)
        if (invValid && (invAll || (cReq[i] == invReqId && cIdx[i] == invIndex))) cVal[i] = 1'b0;
      if (doFill) begin
        cVal[ptr] = 1'b1; cReq[ptr] = pReq; cIdx[ptr] = pIdx;
        cVec[ptr] = memRspData[15:8]; cDst[ptr] = memRspData[31:24];
        ptr = (ptr + 1) % WAYS;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rstN && running) begin
      check(msgReady == (mState == 0), "R2 msgReady", 64'(msgReady), 64'(mState == 0));
      check(memReqValid == (mState == 1), "R2 memReqValid", 64'(memReqValid), 64'(mState == 1));
      if (mState == 1)
        check(memReqAddr == {pReq, pIdx}, "R2 memReqAddr", 64'(memReqAddr), 64'({pReq, pIdx}));
      check(irqValid == mIrq, "R3/R6 irqValid", 64'(irqValid), 64'(mIrq));
      if (mIrq) begin
        check(irqVector == mVec, "R3/R6 irqVector", 64'(irqVector), 64'(mVec));
        check(irqDest == mDst, "R3/R6 irqDest", 64'(irqDest), 64'(mDst));
      end
      check(errPulse == mErr, "R4/R5 errPulse", 64'(errPulse), 64'(mErr));
      if (mErr)
        check(errReqId == mErrId, "R4/R5 errReqId", 64'(errReqId), 64'(mErrId));
      if (irqValid) irqs++;
      if (errPulse) errs++;
    end
  end

  // ---------------- table memory ----------------
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspCnt > 0) begin
      rspCnt--;
      if (rspCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = entryFor(rdAddr, epoch);
      end
    end
    if (rstN && memReqValid && rspCnt == 0) begin
      rdAddr = memReqAddr;
      rspCnt = memLat;
      reads++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic sendMsg(input logic [REQ_W-1:0] r, input logic [IDX_W-1:0] i);
    @(negedge clk);
    msgValid = 1'b1; msgReqId = r; msgIndex = i;
    while (!msgReady) @(negedge clk);
    @(negedge clk);
    msgValid = 1'b0;
  endtask

  task automatic sendWithInv(input logic [REQ_W-1:0] r, input logic [IDX_W-1:0] i);
    @(negedge clk);
    while (!msgReady) @(negedge clk);
    msgValid = 1'b1; msgReqId = r; msgIndex = i;
    invValid = 1'b1; invAll = 1'b0; invReqId = r; invIndex = i[AW-1:0];
    @(negedge clk);
    msgValid = 1'b0; invValid = 1'b0;
  endtask

  task automatic invalidate(input bit all, input logic [REQ_W-1:0] r, input logic [AW-1:0] i);
    @(negedge clk);
    invValid = 1'b1; invAll = all; invReqId = r; invIndex = i;
    @(negedge clk);
    invValid = 1'b0; invAll = 1'b0;
  endtask

  task automatic settle();
    repeat (memLat + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int r0, i0, e0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(msgReady == 1'b1, "R1 msgReady", 64'(msgReady), 64'd1);
    check(irqValid == 1'b0, "R1 irqValid", 64'(irqValid), 64'd0);
    check(errPulse == 1'b0, "R1 errPulse", 64'(errPulse), 64'd0);
    check(memReqValid == 1'b0, "R1 memReqValid", 64'(memReqValid), 64'd0);
    running = 1'b1;

    // R3: miss, valid entry delivered
    r0 = reads; i0 = irqs;
    sendMsg(16'h0102, 8'd1); settle();
    check(reads - r0 == 1 && irqs - i0 == 1, "R3 miss delivers", 64'(reads - r0), 64'd1);

    // R6: same key hits
    r0 = reads; i0 = irqs;
    sendMsg(16'h0102, 8'd1); settle();
    check(reads - r0 == 0 && irqs - i0 == 1, "R6 hit no read", 64'(reads - r0), 64'd0);

    // R4 and R7: invalid entry, read each time
    r0 = reads; i0 = irqs; e0 = errs;
    sendMsg(16'h0102, 8'd3); settle();
    check(errs - e0 == 1 && irqs - i0 == 0, "R4 invalid entry dropped", 64'(errs - e0), 64'd1);
    sendMsg(16'h0102, 8'd3); settle();
    check(reads - r0 == 2, "R7 invalid entry not cached", 64'(reads - r0), 64'd2);

    // R5: boundary index 32 and far index 200 out of range; 31 in range
    r0 = reads; e0 = errs;
    sendMsg(16'h0777, 8'd32); settle();
    sendMsg(16'h0778, 8'd200); settle();
    check(reads - r0 == 0 && errs - e0 == 2, "R5 out of range", 64'(reads - r0), 64'd0);
    sendMsg(16'h0779, 8'd31); settle();
    check(reads - r0 == 1, "R5 last index in range", 64'(reads - r0), 64'd1);

    // R8: fill 7 more keys, first still hits; ninth fill evicts it
    for (int k = 1; k <= 7; k++) begin
      sendMsg(16'h0200 + 16'(k), 8'd0); settle();
    end
    r0 = reads;
    sendMsg(16'h0102, 8'd1); settle();
    check(reads - r0 == 0, "R8 eight ways held", 64'(reads - r0), 64'd0);
    sendMsg(16'h0300, 8'd0); settle();
    r0 = reads;
    sendMsg(16'h0202, 8'd0); settle();
    check(reads - r0 == 0, "R8 younger way kept", 64'(reads - r0), 64'd0);
    sendMsg(16'h0102, 8'd1); settle();
    check(reads - r0 == 1, "R8 oldest evicted", 64'(reads - r0), 64'd1);

    // R9: table changes; cached key stays stale until invalidated
    epoch = 8'h33;
    r0 = reads;
    sendMsg(16'h0203, 8'd0); settle();
    check(reads - r0 == 0, "R9 stale hit before invalidation", 64'(reads - r0), 64'd0);
    invalidate(1'b0, 16'h0203, 5'd0);
    sendMsg(16'h0203, 8'd0); settle();
    check(reads - r0 == 1, "R9 keyed invalidation", 64'(reads - r0), 64'd1);
    sendMsg(16'h0204, 8'd0); settle();
    check(reads - r0 == 1, "R9 other key untouched", 64'(reads - r0), 64'd1);
    invalidate(1'b1, 16'h0000, 5'd0);
    sendMsg(16'h0204, 8'd0); settle();
    sendMsg(16'h0300, 8'd0); settle();
    check(reads - r0 == 3, "R9 invalidate all", 64'(reads - r0), 64'd3);
    r0 = reads;
    sendWithInv(16'h0204, 8'd0); settle();
    check(reads - r0 == 1, "R9 same-cycle invalidation misses", 64'(reads - r0), 64'd1);

    // R10: invalidation while the read is in flight
    memLat = 6;
    sendMsg(16'h0400, 8'd2); settle();
    invalidate(1'b1, 16'h0000, 5'd0);
    r0 = reads; i0 = irqs;
    @(negedge clk);
    msgValid = 1'b1; msgReqId = 16'h0400; msgIndex = 8'd2;
    @(negedge clk);
    msgValid = 1'b0;
    repeat (2) @(negedge clk);
    invalidate(1'b0, 16'h0400, 5'd2);
    settle();
    check(irqs - i0 == 1, "R10 in-flight delivered", 64'(irqs - i0), 64'd1);
    sendMsg(16'h0400, 8'd2); settle();
    check(reads - r0 == 2, "R10 in-flight not cached", 64'(reads - r0), 64'd2);

    // R2: miss followed at once by a hit; order kept by the stall
    memLat = 3;
    i0 = irqs;
    sendMsg(16'h0500, 8'd1);
    sendMsg(16'h0400, 8'd2);
    settle();
    check(irqs - i0 == 2, "R2 ordered pair delivered", 64'(irqs - i0), 64'd2);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule